// File: doc/BRIEF.md
# Fault-Tolerant Three-State Controller

This block is a small sequencing controller with three working states, here called A, B and C, stepped by a single start input. A waits in A until start is seen, then runs once through B and C and returns to A. Its state register does not hold a plain state number. It holds a protected code word. Every cycle the stored word is decoded before the next state is chosen.

A single flipped bit in the word is corrected on the fly, and the controller keeps running as though nothing happened. Any word that is not a working state sends the controller to a recovery state. That covers the spare code, words that cannot be corrected, and a word that decodes to the spare state. The recovery state is set by a parameter. This means no stored value can trap the machine.

Three storage encodings are selected by a parameter: a dense 2-bit binary form, a 4-bit one-hot form and a 5-bit distance-3 form. Only the distance-3 form corrects errors. A test-only mask input flips chosen bits of the word as it is written, so that upsets can be injected.

Top module: `safe_fsm`

## Requirements
- R1: While rst is high at a rising clock edge, the register is loaded with the code for A; after that edge state_o is 0 (A) and both flags are low. State numbers are A=0, B=1, C=2, and 3 is the spare.
- R2: In A, the next state is B when start is high and A otherwise.
- R3: B always moves to C, and C always moves to A, whatever start is.
- R4: ENC_MODE selects the stored code. Mode 0 stores the state number in 2 bits (A=00, B=01, C=10). Mode 1 stores one-hot in 4 bits (A=0001, B=0010, C=0100, 1000 is the spare). Mode 2 stores 5 bits {s1,s0,s1,s0,s1^s0}, and any two of its four code words differ in at least 3 bits.
- R5: In mode 2, a stored word one bit away from the code of A, B or C makes state_o show that state and raises corrected_err. The transition of that cycle starts from the corrected state.
- R6: A stored word that is not a working state raises illegal_err. In mode 0 that is 11. In mode 1 it is any word without exactly one bit set, or 1000. In mode 2 it is a word at distance 2 or more from every code word, or one that decodes to the spare. While illegal_err is high, state_o shows the recovery state and the next state is the recovery state, whatever start is.
- R7: The recovery state is the parameter REC_STATE (0, 1 or 2), and it defaults to A.
- R8: A flag lasts only while the faulty word is held. After one injected upset with no further injection, both flags are low one cycle later.
- R9: The register is written with the next-state code XOR inj_mask. Mask bits above the code width have no effect.
- R10: corrected_err and illegal_err are never high together, and state_o is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leave A for B |
| inj_mask | input | 5 | Test-only bit flips applied to the written code word |
| state_o | output | 2 | Decoded current state (A=0, B=1, C=2) |
| corrected_err | output | 1 | Stored word had a single correctable bit error |
| illegal_err | output | 1 | Stored word was not a working state; recovery taken |

## Verification
A corrupted register shows up at the ports in the very cycle after the write that corrupted it. Either corrected_err rises while state_o keeps the intended state, or illegal_err rises while state_o shows the recovery state. One edge later, the sequence shows whether the right state was used. A corrected word must step on normally. A recovered word must sit in the recovery state even though start is high. A clean word must leave both flags low at once. Double-bit upsets, the spare code and mask bits above the code width are each injected into every encoding that can hold them.

// File: rtl/safe_fsm.sv
module safe_fsm #(
  parameter int         ENC_MODE  = 2,
  parameter logic [1:0] REC_STATE = 2'd0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [4:0] inj_mask,
  output logic [1:0] state_o,
  output logic       corrected_err,
  output logic       illegal_err
);
  localparam int W = (ENC_MODE == 0) ? 2 : (ENC_MODE == 1) ? 4 : 5;
  localparam logic [1:0] S_A = 2'd0, S_B = 2'd1, S_C = 2'd2, S_X = 2'd3;

  function automatic logic [W-1:0] encode(input logic [1:0] s);
    logic [4:0] c;
    case (ENC_MODE)
      0:       c = {3'b000, s};
      1:       c = 5'd1 << s;
      default: c = {s[1], s[0], s[1], s[0], s[1] ^ s[0]};
    endcase
    return c[W-1:0];
  endfunction

  logic [W-1:0] code_q, code_d;
  logic [1:0]   dec_s, nxt_s;
  logic         hit, fix, legal;

  always_comb begin
    hit   = 1'b0;
    fix   = 1'b0;
    dec_s = REC_STATE;
    for (int k = 0; k < 4; k++) begin
      if (code_q == encode(2'(k))) begin
        hit   = 1'b1;
        dec_s = 2'(k);
      end else if (ENC_MODE == 2 && $countones(code_q ^ encode(2'(k))) == 1) begin
        fix   = 1'b1;
        dec_s = 2'(k);
      end
    end
  end

  assign legal         = (hit || fix) && dec_s != S_X;
  assign state_o       = legal ? dec_s : REC_STATE;
  assign corrected_err = legal && fix;
  assign illegal_err   = !legal;

  always_comb begin
    if (!legal) nxt_s = REC_STATE;
    else begin
      case (state_o)
        S_A:     nxt_s = start ? S_B : S_A;
        S_B:     nxt_s = S_C;
        S_C:     nxt_s = S_A;
        default: nxt_s = REC_STATE;
      endcase
    end
  end

  assign code_d = encode(nxt_s) ^ inj_mask[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) code_q <= encode(S_A);
    else     code_q <= code_d;
  end

  a_r1_reset_to_a: assert property (@(posedge clk)
    rst |=> state_o == S_A && !corrected_err && !illegal_err);

  a_r2_a_holds_or_starts: assert property (@(posedge clk) disable iff (rst)
    (legal && state_o == S_A && inj_mask == 5'd0)
      |=> state_o == ($past(start) ? S_B : S_A) && !illegal_err);

  a_r3_b_then_c: assert property (@(posedge clk) disable iff (rst)
    (legal && state_o == S_B && inj_mask == 5'd0) |=> state_o == S_C);

  a_r3_c_then_a: assert property (@(posedge clk) disable iff (rst)
    (legal && state_o == S_C && inj_mask == 5'd0) |=> state_o == S_A);

  a_r6_recover: assert property (@(posedge clk) disable iff (rst)
    (illegal_err && inj_mask == 5'd0)
      |=> state_o == REC_STATE && !illegal_err && !corrected_err);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(corrected_err && illegal_err) && state_o != S_X);

  generate
    if (ENC_MODE != 2) begin : g_nofix
      a_r5_no_fix_without_distance: assert property (@(posedge clk) disable iff (rst)
        !corrected_err);
    end
  endgenerate
endmodule

// File: tb/test_safe_fsm.sv
module test_safe_fsm;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [4:0] inj_h = '0, inj_b = '0, inj_o = '0;
  logic [1:0] st_h, st_b, st_o;
  logic ce_h, ie_h, ce_b, ie_b, ce_o, ie_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  safe_fsm #(.ENC_MODE(2), .REC_STATE(2'd0)) i_safe_fsm (
    .clk(clk), .rst(rst), .start(start), .inj_mask(inj_h),
    .state_o(st_h), .corrected_err(ce_h), .illegal_err(ie_h));
  safe_fsm #(.ENC_MODE(0), .REC_STATE(2'd2)) i_safe_fsm_bin (
    .clk(clk), .rst(rst), .start(start), .inj_mask(inj_b),
    .state_o(st_b), .corrected_err(ce_b), .illegal_err(ie_b));
  safe_fsm #(.ENC_MODE(1), .REC_STATE(2'd0)) i_safe_fsm_oh (
    .clk(clk), .rst(rst), .start(start), .inj_mask(inj_o),
    .state_o(st_o), .corrected_err(ce_o), .illegal_err(ie_o));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] st, input logic ce, input logic ie,
                     input logic [1:0] est, input logic ece, input logic eie);
    checks++;
    if (st !== est || ce !== ece || ie !== eie) begin
      errors++;
      $display("FAIL %s: state/corr/ill = %0d/%0b/%0b, expected %0d/%0b/%0b",
               req, st, ce, ie, est, ece, eie);
    end
  endtask

  task automatic do_reset();
    start = 0; inj_h = '0; inj_b = '0; inj_o = '0;
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_sequence();
    do_reset();
    chk("R1 reset hamming", st_h, ce_h, ie_h, 0, 0, 0);
    chk("R1 reset binary", st_b, ce_b, ie_b, 0, 0, 0);
    chk("R1 reset onehot", st_o, ce_o, ie_o, 0, 0, 0);
    tick();
    chk("R2 A holds without start", st_h, ce_h, ie_h, 0, 0, 0);
    start = 1; tick(); start = 0;
    chk("R2 A to B on start", st_h, ce_h, ie_h, 1, 0, 0);
    chk("R4 onehot A to B", st_o, ce_o, ie_o, 1, 0, 0);
    start = 1; tick();
    chk("R3 B to C ignoring start", st_h, ce_h, ie_h, 2, 0, 0);
    tick(); start = 0;
    chk("R3 C to A ignoring start", st_h, ce_h, ie_h, 0, 0, 0);
    chk("R4 binary back in A", st_b, ce_b, ie_b, 0, 0, 0);
  endtask

  task automatic t_correct();
    do_reset();
    inj_h = 5'b00100; tick(); inj_h = '0;
    chk("R5 single flip in A corrected", st_h, ce_h, ie_h, 0, 1, 0);
    start = 1; tick(); start = 0;
    chk("R5 R8 corrected A steps to B, flag gone", st_h, ce_h, ie_h, 1, 0, 0);
    inj_h = 5'b00001; tick(); inj_h = '0;
    chk("R5 single flip lands in C corrected", st_h, ce_h, ie_h, 2, 1, 0);
    tick();
    chk("R5 corrected C steps to A", st_h, ce_h, ie_h, 0, 0, 0);
    inj_h = 5'b10000; tick(); inj_h = '0;
    chk("R5 state bit flip corrected", st_h, ce_h, ie_h, 0, 1, 0);
  endtask

  task automatic t_illegal();
    do_reset();
    inj_h = 5'b11000; tick(); inj_h = '0;
    chk("R6 double flip illegal", st_h, ce_h, ie_h, 0, 0, 1);
    start = 1; tick(); start = 0;
    chk("R6 R8 recovery ignores start", st_h, ce_h, ie_h, 0, 0, 0);
    inj_h = 5'b11111; tick(); inj_h = '0;
    chk("R6 word decoding to spare is illegal", st_h, ce_h, ie_h, 0, 0, 1);
    tick();
    chk("R8 flag clears after recovery", st_h, ce_h, ie_h, 0, 0, 0);
  endtask

  task automatic t_binary();
    do_reset();
    inj_b = 5'b00011; tick(); inj_b = '0;
    chk("R6 R7 binary 11 shows recovery C", st_b, ce_b, ie_b, 2, 0, 1);
    tick();
    chk("R7 binary recovered into C", st_b, ce_b, ie_b, 2, 0, 0);
    tick();
    chk("R3 binary C to A after recovery", st_b, ce_b, ie_b, 0, 0, 0);
    inj_b = 5'b11100; tick(); inj_b = '0;
    chk("R9 mask bits above width ignored", st_b, ce_b, ie_b, 0, 0, 0);
  endtask

  task automatic t_onehot();
    do_reset();
    inj_o = 5'b00010; tick(); inj_o = '0;
    chk("R6 onehot two bits set illegal", st_o, ce_o, ie_o, 0, 0, 1);
    tick();
    chk("R8 onehot flag clears", st_o, ce_o, ie_o, 0, 0, 0);
    inj_o = 5'b01001; tick(); inj_o = '0;
    chk("R6 onehot spare code 1000 illegal", st_o, ce_o, ie_o, 0, 0, 1);
    tick();
    inj_o = 5'b00001; tick(); inj_o = '0;
    chk("R6 onehot all-zero illegal", st_o, ce_o, ie_o, 0, 0, 1);
    inj_o = 5'b10000; tick(); inj_o = '0;
    chk("R9 onehot high mask bit ignored", st_o, ce_o, ie_o, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_sequence();
    t_correct();
    t_illegal();
    t_binary();
    t_onehot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule